// File: doc/BRIEF.md
# Way-Reserving Shared Cache Controller

This block makes the allocation and replacement decisions for a set-associative cache that two hardware threads share. It holds, for every set, a valid bit, a tag and an age per way. For each request it gives back at once whether the line is present and which way it occupies, or, on a miss, which way receives the fill. The data array and the memory behind the cache are outside the block.

The controller has two operating modes. In the open mode either thread may fill any way. When a thread start is signalled, the controller moves to the split mode. In the split mode each thread owns a fixed group of ways that only it may fill, and the remaining ways form a pool that both threads fill. On the way into the split mode and on the way out, the owned ways are emptied in every set, so no line crosses between the modes. The controller leaves the split mode on its own after one of the threads has stayed idle for a set number of cycles. A hit is served from any way, so data that both threads read still hits in the split mode.

Top module: `wrsv_cache_ctl`

## Requirements
- R1: After reset the controller is in the open mode (`part_mode` = 0) and every line is invalid, so a first request misses and is given way 0.
- R2: A request whose tag matches a valid line of the addressed set reports `rsp_hit` = 1 and that line's way, whichever thread filled it and whichever ways are owned.
- R3: On a miss the fill way is the lowest-numbered invalid way the requester may fill. If there is none, it is the least recently used way it may fill. Both hits and fills make the accessed way the most recently used one in its set.
- R4: In the open mode all `WAYS` ways may be filled by either thread.
- R5: In the split mode thread 0 owns ways 0 to RSV-1 and thread 1 owns ways RSV to 2·RSV-1. Ways from 2·RSV upward are shared. A miss never fills the other thread's owned ways.
- R6: A `thread_start` pulse in the open mode sets `part_mode` at the next clock edge and invalidates ways 0 to 2·RSV-1 of every set at that edge. A pulse in the split mode has no effect on the mode or on the lines.
- R7: In the split mode each thread has its own count of consecutive cycles without a request from it, and a request from that thread clears the count. In the cycle where either count would reach `TIMEOUT`, the controller returns to the open mode at that edge and invalidates ways 0 to 2·RSV-1 of every set.
- R8: A mode change invalidates the owned ways even when a request fills one of them in the same cycle.
- R9: Lines in the shared ways stay valid across mode changes and keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_tid | input | 1 | Requesting thread, 0 or 1 |
| req_set | input | $clog2(SETS) | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| thread_start | input | 1 | Pulse marking the start of a thread |
| rsp_hit | output | 1 | The request hits; valid while `req_valid` is 1 |
| rsp_way | output | $clog2(WAYS) | Hit way, or the fill way on a miss |
| part_mode | output | 1 | 1 while the split mode is active |

## Verification
The properties assume that a miss is followed at the same edge by the fill the controller chose, so no tag ever sits in two ways of one set. They also assume that `req_tid` and `thread_start` are clean single-bit values whenever the clock samples them. The stimulus presents at most one request per cycle and never repeats a tag within a set except as a lookup. It keeps to a fixed test configuration of four sets, and every thread-start pulse lasts one cycle. Idle gaps are made long enough to cross the timeout and, elsewhere, kept one cycle short of it.

// File: rtl/wrsv_pkg.sv
package wrsv_pkg;

  typedef enum logic {
    MODE_OPEN  = 1'b0,
    MODE_SPLIT = 1'b1
  } mode_e;

  // Fill permission of one way for one thread under the current mode.
  function automatic logic way_allowed(input int unsigned way,
                                       input int unsigned rsv,
                                       input logic        split,
                                       input logic        tid);
    logic shared_w;
    logic own_w;
    shared_w = (way >= 2 * rsv);
    own_w    = tid ? ((way >= rsv) && (way < 2 * rsv)) : (way < rsv);
    return !split || shared_w || own_w;
  endfunction

endpackage

// File: rtl/wrsv_hit_detect.sv
module wrsv_hit_detect #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 6,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       row_vld,
  input  logic [WAYS*TAG_W-1:0] row_tags,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = row_vld[w] && (row_tags[w*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/wrsv_victim_pick.sv
module wrsv_victim_pick
  import wrsv_pkg::*;
#(
  parameter int unsigned WAYS = 8,
  parameter int unsigned RSV  = 2,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned AGE_W = WAY_W
) (
  input  logic [WAYS-1:0]       row_vld,
  input  logic [WAYS*AGE_W-1:0] row_age,
  input  logic                  split,
  input  logic                  tid,
  output logic [WAY_W-1:0]      victim
);

  logic [WAYS-1:0]  elig;
  logic             have_free;
  logic [WAY_W-1:0] free_way;
  logic             have_old;
  logic [WAY_W-1:0] old_way;
  logic [AGE_W-1:0] old_age;

  for (genvar w = 0; w < WAYS; w++) begin : g_elig
    assign elig[w] = way_allowed(w, RSV, split, tid);
  end

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (elig[w] && !row_vld[w]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
    have_old = 1'b0;
    old_way  = '0;
    old_age  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (elig[w] && (!have_old || (row_age[w*AGE_W +: AGE_W] > old_age))) begin
        have_old = 1'b1;
        old_way  = WAY_W'(w);
        old_age  = row_age[w*AGE_W +: AGE_W];
      end
    end
    victim = have_free ? free_way : old_way;
  end

endmodule

// File: rtl/wrsv_mode_ctl.sv
module wrsv_mode_ctl
  import wrsv_pkg::*;
#(
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_tid,
  input  logic thread_start,
  output logic split,
  output logic flush
);

  mode_e            mode_q, mode_d;
  logic [CNT_W-1:0] idle_q [2];
  logic [CNT_W-1:0] idle_d [2];
  logic             expire;
  logic             cnt_en;

  always_comb begin
    mode_d = mode_q;
    flush  = 1'b0;
    expire = 1'b0;
    for (int t = 0; t < 2; t++) idle_d[t] = '0;
    if (mode_q == MODE_OPEN) begin
      if (thread_start) begin
        mode_d = MODE_SPLIT;
        flush  = 1'b1;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (req_valid && (req_tid == 1'(t))) idle_d[t] = '0;
        else                                 idle_d[t] = idle_q[t] + 1'b1;
        if (idle_d[t] == CNT_W'(TIMEOUT)) expire = 1'b1;
      end
      if (expire) begin
        mode_d = MODE_OPEN;
        flush  = 1'b1;
        for (int t = 0; t < 2; t++) idle_d[t] = '0;
      end
    end
  end

  assign cnt_en = (mode_q == MODE_SPLIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OPEN;
      for (int t = 0; t < 2; t++) idle_q[t] <= '0;
    end else begin
      mode_q <= mode_d;
      if (cnt_en) begin
        for (int t = 0; t < 2; t++) idle_q[t] <= idle_d[t];
      end
    end
  end

  assign split = (mode_q == MODE_SPLIT);

endmodule

// File: rtl/wrsv_cache_ctl.sv
module wrsv_cache_ctl #(
  parameter int unsigned WAYS    = 8,
  parameter int unsigned SETS    = 4,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned RSV     = 2,
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned AGE_W  = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_tid,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             thread_start,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic             part_mode
);

  localparam logic [WAYS-1:0] RSV_MASK = WAYS'((64'd1 << (2 * RSV)) - 64'd1);

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-set state
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_d [SETS][WAYS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] age_d [SETS][WAYS];

  logic [WAYS*TAG_W-1:0] row_tags;
  logic [WAYS*AGE_W-1:0] row_age;
  logic [WAYS-1:0]       row_vld;
  logic [SETS*WAYS-1:0]  vld_flat;

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vict_way;
  logic [WAY_W-1:0] acc_way;
  logic             flush;
  logic             split;
  logic             arr_en;

  assign row_vld = vld_q[req_set];
  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_tags[w*TAG_W +: TAG_W] = tag_q[req_set][w];
    assign row_age[w*AGE_W +: AGE_W]  = age_q[req_set][w];
  end
  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign vld_flat[s*WAYS +: WAYS] = vld_q[s];
  end

  wrsv_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
    .row_vld  (row_vld),
    .row_tags (row_tags),
    .tag      (req_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  wrsv_victim_pick #(.WAYS(WAYS), .RSV(RSV)) u_vict (
    .row_vld (row_vld),
    .row_age (row_age),
    .split   (split),
    .tid     (req_tid),
    .victim  (vict_way)
  );

  wrsv_mode_ctl #(.TIMEOUT(TIMEOUT)) u_mode (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .req_tid      (req_tid),
    .thread_start (thread_start),
    .split        (split),
    .flush        (flush)
  );

  assign acc_way = hit ? hit_way : vict_way;

  // next state: access update first, mode-change invalidation overrides it
  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    age_d = age_q;
    if (req_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == acc_way)
          age_d[req_set][w] = '0;
        else if (age_q[req_set][w] < age_q[req_set][acc_way])
          age_d[req_set][w] = age_q[req_set][w] + 1'b1;
      end
      if (!hit) begin
        vld_d[req_set][acc_way] = 1'b1;
        tag_d[req_set][acc_way] = req_tag;
      end
    end
    if (flush) begin
      for (int s = 0; s < SETS; s++) vld_d[s] = vld_d[s] & ~RSV_MASK;
    end
  end

  assign arr_en = req_valid | flush;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (arr_en) begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      age_q <= age_d;
    end
  end

  assign rsp_hit   = hit;
  assign rsp_way   = acc_way;
  assign part_mode = split;

endmodule

// File: rtl/wrsv_cache_ctl_chk.sv
module wrsv_cache_ctl_chk
  import wrsv_pkg::*;
#(
  parameter int unsigned WAYS    = 8,
  parameter int unsigned SETS    = 4,
  parameter int unsigned RSV     = 2,
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_tid,
  input logic [SET_W-1:0]     req_set,
  input logic                 thread_start,
  input logic                 rsp_hit,
  input logic [WAY_W-1:0]     rsp_way,
  input logic                 part_mode,
  input logic [SETS*WAYS-1:0] vld_flat
);

  localparam logic [WAYS-1:0] RSV_MASK = WAYS'((64'd1 << (2 * RSV)) - 64'd1);

  logic [SETS*WAYS-1:0] rsv_all;
  for (genvar s = 0; s < SETS; s++) begin : g_mask
    assign rsv_all[s*WAYS +: WAYS] = RSV_MASK;
  end

  // independent idle tracking per thread
  logic [CNT_W-1:0] idle [2];
  logic             acc  [2];
  logic             due;

  always_comb begin
    due = 1'b0;
    for (int t = 0; t < 2; t++) begin
      acc[t] = req_valid && (req_tid == 1'(t));
      if (part_mode && !acc[t] && (idle[t] == CNT_W'(TIMEOUT - 1))) due = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) idle[t] <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (!part_mode || acc[t] || due) idle[t] <= '0;
        else                             idle[t] <= idle[t] + 1'b1;
      end
    end
  end

  a_r5_fill_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_hit) |-> way_allowed(rsp_way, RSV, part_mode, req_tid));

  a_r2_hit_line_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_hit) |-> vld_flat[int'(req_set) * WAYS + int'(rsp_way)]);

  a_r6_entry_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(part_mode) |-> $past(thread_start));

  a_r6_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(part_mode) |-> ((vld_flat & rsv_all) == '0));

  a_r7_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(part_mode) |-> ((vld_flat & rsv_all) == '0));

  a_r7_stay_split: assert property (@(posedge clk) disable iff (!rst_n)
    (part_mode && !due) |=> part_mode);

  a_r7_exit_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> !part_mode);

endmodule

bind wrsv_cache_ctl wrsv_cache_ctl_chk #(
  .WAYS(WAYS), .SETS(SETS), .RSV(RSV), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .req_valid    (req_valid),
  .req_tid      (req_tid),
  .req_set      (req_set),
  .thread_start (thread_start),
  .rsp_hit      (rsp_hit),
  .rsp_way      (rsp_way),
  .part_mode    (part_mode),
  .vld_flat     (vld_flat)
);

// File: tb/wrsv_cache_ctl_test.sv
`timescale 1ns/1ps
module wrsv_cache_ctl_test;

  localparam int WAYS = 8, SETS = 4, TAG_W = 6, RSV = 2, TIMEOUT = 16;
  localparam int WAY_W = $clog2(WAYS), SET_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_tid = 1'b0;
  logic [SET_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             thread_start = 1'b0;
  logic             rsp_hit;
  logic [WAY_W-1:0] rsp_way;
  logic             part_mode;

  int total = 0, fails = 0;
  bit done = 0;
  int unsigned lfsr = 32'h1bad_c0de;

  // reference state derived from the requirements
  bit mv [SETS][WAYS];
  int mt [SETS][WAYS];
  int mage [SETS][WAYS];
  bit mmode;
  int mcnt [2];

  always #2.5 clk = ~clk;

  wrsv_cache_ctl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .RSV(RSV), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
    .req_set(req_set), .req_tag(req_tag), .thread_start(thread_start),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .part_mode(part_mode));

  task automatic chk(input string r, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic bit may_fill(int w, bit t);
    if (!mmode || w >= 2 * RSV) return 1'b1;
    return t ? (w >= RSV && w < 2 * RSV) : (w < RSV);
  endfunction

  function automatic void predict(int s, int tg, bit t, output bit h, output int w);
    bit found = 0;
    int best = -1;
    h = 0; w = 0;
    for (int i = 0; i < WAYS; i++) if (mv[s][i] && mt[s][i] == tg) begin h = 1; w = i; end
    if (!h) begin
      for (int i = 0; i < WAYS; i++)
        if (!found && may_fill(i, t) && !mv[s][i]) begin found = 1; w = i; end
      if (!found)
        for (int i = 0; i < WAYS; i++)
          if (may_fill(i, t) && mage[s][i] > best) begin best = mage[s][i]; w = i; end
    end
  endfunction

  function automatic void advance(bit v, bit t, int s, int tg, bit st);
    bit h, fl = 0, ex = 0;
    int w, a;
    if (v) begin
      predict(s, tg, t, h, w);
      a = mage[s][w];
      for (int i = 0; i < WAYS; i++) if (i != w && mage[s][i] < a) mage[s][i]++;
      mage[s][w] = 0;
      if (!h) begin mv[s][w] = 1; mt[s][w] = tg; end
    end
    if (!mmode) begin
      if (st) begin mmode = 1; fl = 1; end
    end else begin
      for (int k = 0; k < 2; k++) begin
        mcnt[k] = (v && t == k[0]) ? 0 : mcnt[k] + 1;
        if (mcnt[k] == TIMEOUT) ex = 1;
      end
      if (ex) begin mmode = 0; fl = 1; mcnt[0] = 0; mcnt[1] = 0; end
    end
    if (fl) for (int s2 = 0; s2 < SETS; s2++) for (int i = 0; i < 2 * RSV; i++) mv[s2][i] = 0;
  endfunction

  // one clock: drive, compare the combinational answer, then step the model
  task automatic step(input bit v, input bit t, input int s, input int tg, input bit st,
                      input string r);
    bit eh;
    int ew;
    @(negedge clk);
    req_valid = v; req_tid = t; req_set = SET_W'(s); req_tag = TAG_W'(tg); thread_start = st;
    #1;
    if (v) begin
      predict(s, tg, t, eh, ew);
      chk({r, " hit"}, rsp_hit == eh, int'(rsp_hit), int'(eh));
      chk({r, " way"}, int'(rsp_way) == ew, int'(rsp_way), ew);
    end
    @(posedge clk);
    advance(v, t, s, tg, st);
    #1;
    chk("R7 mode", part_mode == mmode, int'(part_mode), int'(mmode));
  endtask

  function automatic int rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return int'(lfsr & 32'h7fff_ffff);
  endfunction

  initial begin
    for (int s = 0; s < SETS; s++) for (int i = 0; i < WAYS; i++) begin
      mv[s][i] = 0; mt[s][i] = 0; mage[s][i] = i;
    end
    mmode = 0; mcnt[0] = 0; mcnt[1] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset mode", part_mode == 1'b0, int'(part_mode), 0);
    @(negedge clk);
    req_valid = 1; req_tid = 0; req_set = 0; req_tag = 6'd9; #1;
    chk("R1 first miss", rsp_hit == 1'b0, int'(rsp_hit), 0);
    chk("R1 first way", rsp_way == 0, int'(rsp_way), 0);
    req_valid = 0;

    // R4/R3: fill every set in the open mode; invalid ways taken lowest first
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) begin
        @(negedge clk);
        req_valid = 1; req_tid = k[0]; req_set = SET_W'(s); req_tag = TAG_W'(8 * s + k); #1;
        chk("R4 open fill way", int'(rsp_way) == k, int'(rsp_way), k);
        @(posedge clk); advance(1, k[0], s, 8 * s + k, 0);
      end
    // R2: every filled line hits, reverse order
    for (int s = 0; s < SETS; s++)
      for (int k = WAYS - 1; k >= 0; k--) step(1, ~k[0], s, 8 * s + k, 0, "R2");
    // R3: three fresh tags per set replace the oldest lines
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < 3; k++) step(1, k[0], s, 40 + k, 0, "R3");

    // R6 entry; R9 shared lines survive, owned lines miss
    step(0, 0, 0, 0, 1, "R6");
    chk("R6 entered", part_mode == 1'b1, int'(part_mode), 1);
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) step(1, k[0], s, 8 * s + k, 0, "R9");

    // R5: mixed traffic in the split mode
    for (int n = 0; n < 300; n++) begin
      int s = rnd() % SETS;
      int tg = rnd() % 20;
      bit t = n[0] ^ n[3];
      bit eh; int ew;
      predict(s, tg, t, eh, ew);
      if (!eh) chk("R5 allowed way", may_fill(ew, t), ew, -1);
      step(1, t, s, tg, 0, "R5");
    end

    // R6: start pulse while split changes nothing
    step(1, 0, 1, 7, 1, "R6");
    step(1, 1, 1, 7, 0, "R6");
    chk("R6 ignored", part_mode == 1'b1, int'(part_mode), 1);

    // R2: thread 1 hits a line thread 0 placed in its owned way
    step(1, 1, 2, 61, 0, "R2");
    for (int i = 0; i < 6; i++) step(1, i[0], 2, 50 + i, 0, "R2");
    step(1, 0, 3, 62, 0, "R2");
    begin
      bit eh; int ew;
      predict(3, 62, 1, eh, ew);
      chk("R2 cross hit", eh, int'(eh), 1);
      step(1, 1, 3, 62, 0, "R2");
    end

    // R7: thread 1 silent; mode holds for TIMEOUT-1 edges, drops on the next
    step(1, 1, 0, 3, 0, "R7");
    for (int i = 0; i < TIMEOUT - 1; i++) step(1, 0, 0, i % 4, 0, "R7");
    chk("R7 holds before limit", part_mode == 1'b1, int'(part_mode), 1);
    step(1, 0, 0, 5, 0, "R7");
    chk("R7 exit at limit", part_mode == 1'b0, int'(part_mode), 0);
    for (int k = 0; k < 3; k++) step(1, 0, 0, k % 4, 0, "R7");

    // R8: a fill into an owned way in the cycle of entry is dropped
    for (int k = 0; k < WAYS; k++) step(1, 0, 1, 20 + k, 0, "R8");
    step(1, 0, 1, 33, 1, "R8");
    step(1, 1, 1, 33, 0, "R8");

    // R7: requests spaced one short of the limit keep the split mode
    for (int n = 0; n < 4 * TIMEOUT; n++)
      step(1, (n % (TIMEOUT - 1)) == 0, n % SETS, n % 12, 0, "R7");
    chk("R7 kept alive", part_mode == 1'b1, int'(part_mode), 1);

    // random mix with idle cycles and start pulses
    for (int n = 0; n < 2500; n++) begin
      int r = rnd();
      step((r % 5) != 0, (r >> 4) % 7 == 0, (r >> 8) % SETS, (r >> 12) % 24,
           ((r >> 20) % 61) == 0, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule